// File: doc/BRIEF.md
# Ethernet MAC Flow-Control Trigger

This block sits beside a 10/100 MAC transmitter and decides when back-pressure or pausing is needed. In half-duplex operation it forces a collision. It does this by driving a short burst on the byte-wide transmit path, made of a preamble, a start delimiter and four jam bytes. The burst can fire each time a frame is received, each time the receive FIFO overflows, or both.

In full-duplex operation a rising receive-FIFO overflow produces a single pause-frame request. The request carries its header fields, the programmed pause time and the pad length the frame builder needs to reach minimum size. Pause frames received from the link load a quanta counter, and while it runs the block holds back new frame starts.

The transmit datapath uses `jam_en_o`/`jam_byte_o` as an override source during the burst. It sends a pause frame when `pause_req_o` is high and acknowledges it with `pause_ack_i`. It samples `tx_hold_o` before it starts each frame.

Top module: `fc_trigger`

## Requirements
- R1: After reset `jam_en_o`, `pause_req_o` and `tx_hold_o` are low, and `jam_byte_o` is 0x00 whenever `jam_en_o` is low.
- R2: In half-duplex mode (`full_duplex_i`=0) with `bp_frame_en_i`=1, an `rx_frame_i` pulse sampled at clock edge k makes `jam_en_o` high for exactly 12 cycles, starting right after edge k. `jam_byte_o` carries 0x55 seven times, then 0xD5, then 0x99 four times.
- R3: In half-duplex mode with `bp_ovf_en_i`=1, a 0-to-1 transition of `rx_ovf_i` starts the same 12-byte burst. A trigger that arrives while a burst is running neither restarts nor extends it.
- R4: In full-duplex mode with `pause_gen_en_i`=1, a 0-to-1 transition of `rx_ovf_i` sampled at edge k raises `pause_req_o` from edge k on. The request holds until an edge that sees `pause_ack_i`=1. While it is raised, the outputs are: destination 0x0180C2000001, type 0x8808, opcode 0x0001, `pause_time_o` equal to `pause_time_i` as sampled at edge k, and `pause_pad_o` equal to 42.
- R5: Exactly one request is made per overflow. While `rx_ovf_i` stays high after the acknowledge, no new request appears. A new request needs `rx_ovf_i` to fall and then rise again.
- R6: No pause request is made in half-duplex mode or when `pause_gen_en_i`=0. No burst is driven in full-duplex mode.
- R7: In full-duplex mode, an `rx_pause_vld_i` pulse with quanta Q sampled at edge k keeps `tx_hold_o` high for Q*64 cycles after edge k (one quantum is 512 bit times at 8 bits per clock). A new pulse reloads the count, and Q=0 clears the hold at once.
- R8: `tx_hold_o` is low whenever `tx_busy_i` is high, so a frame already in flight is never held.
- R9: `rx_pause_vld_i` has no effect in half-duplex mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | 1 = full-duplex, 0 = half-duplex |
| bp_frame_en_i | input | 1 | Half-duplex: jam on each received frame |
| bp_ovf_en_i | input | 1 | Half-duplex: jam on receive FIFO overflow |
| pause_gen_en_i | input | 1 | Full-duplex: request pause on overflow |
| rx_frame_i | input | 1 | One-cycle pulse per received frame |
| rx_ovf_i | input | 1 | Receive FIFO overflow condition (level) |
| pause_time_i | input | 16 | Pause time placed in generated frames |
| pause_ack_i | input | 1 | Transmitter has taken the pause request |
| rx_pause_vld_i | input | 1 | A valid pause frame was received |
| rx_pause_quanta_i | input | 16 | Quanta decoded from that frame |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| jam_en_o | output | 1 | Transmit enable for the forced collision burst |
| jam_byte_o | output | 8 | Burst byte |
| pause_req_o | output | 1 | Pause frame requested |
| pause_da_o | output | 48 | Pause frame destination address |
| pause_type_o | output | 16 | Pause frame type field |
| pause_opcode_o | output | 16 | Pause frame opcode |
| pause_time_o | output | 16 | Pause time captured at the request |
| pause_pad_o | output | 8 | Pad bytes needed to reach minimum length |
| tx_hold_o | output | 1 | Do not start a new frame |

## Verification
Some properties are checked on every cycle. A burst never starts in full-duplex and always opens with 0x55. The delimiter is always followed by jam. A request only ever rises from a full-duplex, enabled overflow and stays up until acknowledged. Its constant header fields hold while it is raised. The hold is never shown during a busy frame.

Other behaviour only the bench scenarios can show. These cover the exact twelve-byte order and its length, and that retriggers are ignored mid-burst. They also cover the one-request-per-overflow re-arm sequence, capture of the pause time at the request, and hold lengths of exactly Q*64 cycles including reload and clear.

// File: rtl/fc_trigger_pkg.sv
package fc_trigger_pkg;
  localparam logic [47:0] PauseDa      = 48'h0180_C200_0001;
  localparam logic [15:0] PauseType    = 16'h8808;
  localparam logic [15:0] PauseOpcode  = 16'h0001;
  localparam logic [7:0]  PreByte      = 8'h55;
  localparam logic [7:0]  SfdByte      = 8'hD5;
  localparam logic [7:0]  JamByte      = 8'h99;
  localparam logic [7:0]  IdleByte     = 8'h00;
  // header bytes before pad: DA + SA + type + opcode + time
  localparam int unsigned PauseHdrLen  = 18;

  typedef enum logic [1:0] {PH_PRE, PH_SFD, PH_JAM} jam_phase_e;
endpackage

// File: rtl/fc_jam_gen.sv
module fc_jam_gen
  import fc_trigger_pkg::*;
#(
  parameter int unsigned PRE_LEN = 7,
  parameter int unsigned JAM_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       en_o,
  output logic [7:0] byte_o
);
  localparam int unsigned Total = PRE_LEN + 1 + JAM_LEN;
  localparam int unsigned CntW  = $clog2(Total);

  logic            active_q;
  logic [CntW-1:0] cnt_q;
  jam_phase_e      phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (cnt_q == CntW'(Total - 1)) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q < CntW'(PRE_LEN))       phase = PH_PRE;
    else if (cnt_q == CntW'(PRE_LEN)) phase = PH_SFD;
    else                              phase = PH_JAM;
  end

  always_comb begin
    if (!active_q) byte_o = IdleByte;
    else begin
      unique case (phase)
        PH_PRE:  byte_o = PreByte;
        PH_SFD:  byte_o = SfdByte;
        default: byte_o = JamByte;
      endcase
    end
  end

  assign en_o = active_q;
endmodule

// File: rtl/fc_pause_req.sv
module fc_pause_req #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          ack_i,
  input  logic [TW-1:0] time_i,
  output logic          req_o,
  output logic [TW-1:0] time_o
);
  logic          req_q;
  logic [TW-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      time_q <= '0;
    end else if (fire_i) begin
      req_q  <= 1'b1;
      time_q <= time_i;
    end else if (ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign time_o = time_q;
endmodule

// File: rtl/fc_pause_timer.sv
module fc_pause_timer #(
  parameter int unsigned QW      = 16,
  parameter int unsigned CYC_PER_Q = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [QW-1:0] quanta_i,
  output logic          active_o
);
  localparam int unsigned SubW = (CYC_PER_Q > 1) ? $clog2(CYC_PER_Q) : 1;
  localparam logic [SubW-1:0] SubMax = SubW'(CYC_PER_Q - 1);

  logic [QW-1:0]   quanta_q;
  logic [SubW-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quanta_q <= '0;
      sub_q    <= '0;
    end else if (load_i) begin
      quanta_q <= quanta_i;
      sub_q    <= SubMax;
    end else if (quanta_q != '0) begin
      if (sub_q == '0) begin
        quanta_q <= quanta_q - 1'b1;
        sub_q    <= SubMax;
      end else begin
        sub_q <= sub_q - 1'b1;
      end
    end
  end

  assign active_o = (quanta_q != '0);
endmodule

// File: rtl/fc_trigger.sv
module fc_trigger
  import fc_trigger_pkg::*;
#(
  parameter int unsigned PRE_LEN   = 7,
  parameter int unsigned JAM_LEN   = 4,
  parameter int unsigned QW        = 16,
  parameter int unsigned CYC_PER_Q = 64,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          bp_frame_en_i,
  input  logic          bp_ovf_en_i,
  input  logic          pause_gen_en_i,
  input  logic          rx_frame_i,
  input  logic          rx_ovf_i,
  input  logic [QW-1:0] pause_time_i,
  input  logic          pause_ack_i,
  input  logic          rx_pause_vld_i,
  input  logic [QW-1:0] rx_pause_quanta_i,
  input  logic          tx_busy_i,
  output logic          jam_en_o,
  output logic [7:0]    jam_byte_o,
  output logic          pause_req_o,
  output logic [47:0]   pause_da_o,
  output logic [15:0]   pause_type_o,
  output logic [15:0]   pause_opcode_o,
  output logic [QW-1:0] pause_time_o,
  output logic [7:0]    pause_pad_o,
  output logic          tx_hold_o
);
  localparam int unsigned PadLen = MIN_FRAME - PauseHdrLen;

  logic ovf_q, ovf_rise, jam_start, pause_fire, pause_load, pause_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= rx_ovf_i;
  end

  assign ovf_rise   = rx_ovf_i & ~ovf_q;
  assign jam_start  = ~full_duplex_i & ((bp_frame_en_i & rx_frame_i) | (bp_ovf_en_i & ovf_rise));
  assign pause_fire = full_duplex_i & pause_gen_en_i & ovf_rise;
  assign pause_load = full_duplex_i & rx_pause_vld_i;

  fc_jam_gen #(.PRE_LEN(PRE_LEN), .JAM_LEN(JAM_LEN)) u_jam (
    .clk_i, .rst_ni,
    .start_i (jam_start),
    .en_o    (jam_en_o),
    .byte_o  (jam_byte_o)
  );

  fc_pause_req #(.TW(QW)) u_req (
    .clk_i, .rst_ni,
    .fire_i  (pause_fire),
    .ack_i   (pause_ack_i),
    .time_i  (pause_time_i),
    .req_o   (pause_req_o),
    .time_o  (pause_time_o)
  );

  fc_pause_timer #(.QW(QW), .CYC_PER_Q(CYC_PER_Q)) u_timer (
    .clk_i, .rst_ni,
    .load_i   (pause_load),
    .quanta_i (rx_pause_quanta_i),
    .active_o (pause_active)
  );

  assign pause_da_o     = PauseDa;
  assign pause_type_o   = PauseType;
  assign pause_opcode_o = PauseOpcode;
  assign pause_pad_o    = 8'(PadLen);
  // hold gates frame starts only; a running frame masks it
  assign tx_hold_o      = pause_active & ~tx_busy_i;
endmodule

// File: rtl/fc_trigger_chk.sv
module fc_trigger_chk #(
  parameter int unsigned QW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          full_duplex_i,
  input logic          pause_gen_en_i,
  input logic          rx_ovf_i,
  input logic          pause_ack_i,
  input logic          tx_busy_i,
  input logic          jam_en_o,
  input logic [7:0]    jam_byte_o,
  input logic          pause_req_o,
  input logic [15:0]   pause_type_o,
  input logic [15:0]   pause_opcode_o,
  input logic          tx_hold_o
);
  AST_IDLE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni) !jam_en_o |-> jam_byte_o == 8'h00); // R1
  AST_BURST_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(jam_en_o) |-> jam_byte_o == 8'h55); // R2
  AST_SFD_THEN_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni) (jam_en_o && jam_byte_o == 8'hD5) |=> (jam_en_o && jam_byte_o == 8'h99)); // R2
  AST_NO_JAM_FD: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(jam_en_o) |-> $past(!full_duplex_i)); // R6
  AST_REQ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (pause_req_o && !pause_ack_i) |=> pause_req_o); // R4
  AST_REQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni) pause_req_o |-> (pause_type_o == 16'h8808 && pause_opcode_o == 16'h0001)); // R4
  AST_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(pause_req_o) |-> $past(full_duplex_i && pause_gen_en_i && rx_ovf_i)); // R5
  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_busy_i |-> !tx_hold_o); // R8
endmodule

bind fc_trigger fc_trigger_chk #(.QW(QW)) u_fc_trigger_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .full_duplex_i  (full_duplex_i),
  .pause_gen_en_i (pause_gen_en_i),
  .rx_ovf_i       (rx_ovf_i),
  .pause_ack_i    (pause_ack_i),
  .tx_busy_i      (tx_busy_i),
  .jam_en_o       (jam_en_o),
  .jam_byte_o     (jam_byte_o),
  .pause_req_o    (pause_req_o),
  .pause_type_o   (pause_type_o),
  .pause_opcode_o (pause_opcode_o),
  .tx_hold_o      (tx_hold_o)
);

// File: tb/fc_trigger_bench.sv
module fc_trigger_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        full_duplex = 1'b0, bp_frame_en = 1'b0, bp_ovf_en = 1'b0, pause_gen_en = 1'b0;
  logic        rx_frame = 1'b0, rx_ovf = 1'b0, pause_ack = 1'b0, rx_pause_vld = 1'b0, tx_busy = 1'b0;
  logic [15:0] pause_time = '0, rx_pause_quanta = '0;
  logic        jam_en, pause_req, tx_hold;
  logic [7:0]  jam_byte, pause_pad;
  logic [47:0] pause_da;
  logic [15:0] pause_type, pause_opcode, pause_time_o;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fc_trigger u_fc_trigger (
    .clk_i(clk), .rst_ni(rst_n),
    .full_duplex_i(full_duplex), .bp_frame_en_i(bp_frame_en), .bp_ovf_en_i(bp_ovf_en),
    .pause_gen_en_i(pause_gen_en), .rx_frame_i(rx_frame), .rx_ovf_i(rx_ovf),
    .pause_time_i(pause_time), .pause_ack_i(pause_ack),
    .rx_pause_vld_i(rx_pause_vld), .rx_pause_quanta_i(rx_pause_quanta), .tx_busy_i(tx_busy),
    .jam_en_o(jam_en), .jam_byte_o(jam_byte), .pause_req_o(pause_req),
    .pause_da_o(pause_da), .pause_type_o(pause_type), .pause_opcode_o(pause_opcode),
    .pause_time_o(pause_time_o), .pause_pad_o(pause_pad), .tx_hold_o(tx_hold)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] burst_byte(input int i);
    if (i < 7) return 8'h55;
    if (i == 7) return 8'hD5;
    return 8'h99;
  endfunction

  // trigger already driven; observe 12 burst cycles (or none) and the idle after
  task automatic watch_burst(input bit yes, input string req);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (i == 0) rx_frame = 1'b0;
      chk(req, {63'd0, jam_en}, {63'd0, yes && i < 12});
      chk(req, {56'd0, jam_byte}, {56'd0, (yes && i < 12) ? burst_byte(i) : 8'h00});
    end
  endtask

  task automatic load_pause(input logic [15:0] q);
    @(negedge clk);
    rx_pause_vld = 1'b1;
    rx_pause_quanta = q;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {63'd0, jam_en}, 64'd0);
    chk("R1", {56'd0, jam_byte}, 64'd0);
    chk("R1", {63'd0, pause_req}, 64'd0);
    chk("R1", {63'd0, tx_hold}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {63'd0, jam_en | pause_req | tx_hold}, 64'd0);

    // R2 R3 R6 burst sweep over mode, enables and trigger kind
    for (int fd = 0; fd < 2; fd++)
      for (int bf = 0; bf < 2; bf++)
        for (int bo = 0; bo < 2; bo++)
          for (int tk = 0; tk < 2; tk++) begin
            @(negedge clk);
            full_duplex = fd[0];
            bp_frame_en = bf[0];
            bp_ovf_en = bo[0];
            pause_gen_en = 1'b0;
            if (tk == 0) rx_frame = 1'b1;
            else rx_ovf = 1'b1;
            watch_burst(fd == 0 && (tk == 0 ? bf == 1 : bo == 1),
                        fd == 1 ? "R6" : (tk == 0 ? "R2" : "R3"));
            chk("R6", {63'd0, pause_req}, 64'd0);
            rx_ovf = 1'b0;
            @(negedge clk);
          end

    // R3 retrigger during a burst is ignored
    @(negedge clk);
    full_duplex = 1'b0; bp_frame_en = 1'b1; bp_ovf_en = 1'b1;
    rx_frame = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      rx_frame = (i == 4);
      if (i == 6) rx_ovf = 1'b1;
      chk("R3", {63'd0, jam_en}, {63'd0, i < 12});
      chk("R3", {56'd0, jam_byte}, {56'd0, i < 12 ? burst_byte(i) : 8'h00});
    end
    rx_ovf = 1'b0; bp_frame_en = 1'b0; bp_ovf_en = 1'b0;
    @(negedge clk);

    // R4 R5 R6 pause request sweep
    for (int fd = 0; fd < 2; fd++)
      for (int en = 0; en < 2; en++) begin
        logic [15:0] t;
        bit exp_req;
        t = 16'h1234 * 16'(fd * 2 + en + 1);
        exp_req = (fd == 1 && en == 1);
        @(negedge clk);
        full_duplex = fd[0]; pause_gen_en = en[0]; pause_time = t; rx_ovf = 1'b1;
        @(negedge clk);
        pause_time = ~t;
        chk(exp_req ? "R4" : "R6", {63'd0, pause_req}, {63'd0, exp_req});
        if (exp_req) begin
          chk("R4", {16'd0, pause_da}, 64'h0000_0180_C200_0001);
          chk("R4", {48'd0, pause_type}, 64'h8808);
          chk("R4", {48'd0, pause_opcode}, 64'h0001);
          chk("R4", {48'd0, pause_time_o}, {48'd0, t});
          chk("R4", {56'd0, pause_pad}, 64'd42);
        end
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk("R4", {63'd0, pause_req}, {63'd0, exp_req});
        end
        pause_ack = 1'b1;
        @(negedge clk);
        pause_ack = 1'b0;
        chk("R4", {63'd0, pause_req}, 64'd0);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk("R5", {63'd0, pause_req}, 64'd0);
        end
        rx_ovf = 1'b0;
        @(negedge clk);
        rx_ovf = 1'b1;
        @(negedge clk);
        chk("R5", {63'd0, pause_req}, {63'd0, exp_req});
        if (exp_req) chk("R5", {48'd0, pause_time_o}, {48'd0, ~t});
        pause_ack = 1'b1;
        @(negedge clk);
        pause_ack = 1'b0; rx_ovf = 1'b0;
        chk("R5", {63'd0, pause_req}, 64'd0);
      end
    pause_gen_en = 1'b0;

    // R7 hold length Q*64 for several Q
    full_duplex = 1'b1;
    for (int q = 1; q <= 3; q++) begin
      load_pause(16'(q));
      for (int k = 0; k <= q * 64; k++) begin
        @(negedge clk);
        if (k == 0) rx_pause_vld = 1'b0;
        chk("R7", {63'd0, tx_hold}, {63'd0, k < q * 64});
      end
    end

    // R7 zero quanta clears
    load_pause(16'd3);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 0) rx_pause_vld = 1'b0;
      chk("R7", {63'd0, tx_hold}, 64'd1);
    end
    load_pause(16'd0);
    @(negedge clk);
    rx_pause_vld = 1'b0;
    chk("R7", {63'd0, tx_hold}, 64'd0);

    // R7 reload restarts the count
    load_pause(16'd1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 0) rx_pause_vld = 1'b0;
    end
    chk("R7", {63'd0, tx_hold}, 64'd1);
    load_pause(16'd2);
    for (int k = 0; k <= 128; k++) begin
      @(negedge clk);
      if (k == 0) rx_pause_vld = 1'b0;
      chk("R7", {63'd0, tx_hold}, {63'd0, k < 128});
    end

    // R8 busy masks the hold
    load_pause(16'd2);
    @(negedge clk);
    rx_pause_vld = 1'b0;
    tx_busy = 1'b1;
    #1 chk("R8", {63'd0, tx_hold}, 64'd0);
    @(negedge clk);
    chk("R8", {63'd0, tx_hold}, 64'd0);
    tx_busy = 1'b0;
    #1 chk("R8", {63'd0, tx_hold}, 64'd1);
    load_pause(16'd0);
    @(negedge clk);
    rx_pause_vld = 1'b0;

    // R9 pause frames ignored in half-duplex
    full_duplex = 1'b0;
    load_pause(16'd2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 0) rx_pause_vld = 1'b0;
      chk("R9", {63'd0, tx_hold}, 64'd0);
    end

    finish_run();
  end
endmodule